// File: doc/BRIEF.md
# Gated Binary Clock Divider

This block divides one input clock into three square-wave outputs at one half, one quarter and one eighth of the input frequency. All three outputs come from a single binary toggle chain clocked on the rising edge, so every output transition lines up with a rising edge of the input clock. The chain keeps its phase relationship under every sequence of freeze, resume and reset.

A freeze control, `en` (active high), stops the chain without glitches. `en` is sampled on the falling clock edge, and that sampled value gates the rising edges that follow. An asserted `en` therefore takes effect from the first falling edge after it is raised, and a deasserted `en` takes effect from the next falling edge after it is lowered. While frozen, the chain holds its count and the outputs stay static. On release it continues from the held count.

The master reset `mr` is asynchronous and active high. It clears the chain and all outputs at once. Its release passes through a falling-edge stage and then a rising-edge stage. As a result, counting resumes on the second rising edge when `mr` is released while `clk` is high, and on the third rising edge when it is released while `clk` is low. There is no streaming data path; all pins are plain clock and control signals.

Top module: `clkdiv_gated_top`

## Requirements
- R1: Once counting is enabled, q0 toggles on every rising edge of clk, giving clk/2.
- R2: q1 toggles on exactly those counting rising edges at which q0 was 1 just before the edge, giving clk/4.
- R3: q2 toggles on exactly those counting rising edges at which q0 and q1 were both 1 just before the edge, giving clk/8. The value {q2,q1,q0} steps up by one per counting edge and wraps from 7 to 0.
- R4: A high level of en present at a falling edge of clk freezes the outputs on the following rising edge. This holds whether en was raised during the high or the low phase of clk.
- R5: After en falls, the first falling edge that samples it low re-enables counting. The next rising edge advances the held value by one.
- R6: While mr is high, q0, q1 and q2 are 0 immediately, with no clock edge needed, and they stay 0 across clock edges.
- R7: If mr falls while clk is high, the outputs hold 0 at the first rising edge after the release and q0 goes to 1 at the second.
- R8: If mr falls while clk is low, the outputs hold 0 at the first and second rising edges after the release and q0 goes to 1 at the third.
- R9: A pulse on en that rises and falls within a single high phase of clk covers no falling edge and does not stop the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| mr | input | 1 | Asynchronous master reset, active high |
| en | input | 1 | Freeze control, active high, sampled on the falling edge of clk |
| q0 | output | 1 | clk divided by 2 |
| q1 | output | 1 | clk divided by 4 |
| q2 | output | 1 | clk divided by 8 |

## Verification
The bench builds the block with its default chain width of three stages, which maps exactly onto q0 to q2. The full eight-state cycle is therefore short enough to cover the 7-to-0 wrap inside the stimulus table. Within a few dozen cycles, that width also reaches freezes whose en change falls in the low phase and in the high phase, a resume from a held non-zero count, and reset releases in both clock phases.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  // Default number of toggle stages in the divider chain.
  localparam int unsigned CHAIN_W_DEF = 3;
  // Number of divided outputs brought to the pins.
  localparam int unsigned OUT_W = 3;
endpackage

// File: rtl/clkdiv_freeze_retime.sv
`timescale 1ns/1ps
// Samples the freeze request on the falling clock edge so the rising-edge
// chain only ever sees a level that is settled for a full half period.
module clkdiv_freeze_retime (
  input  logic clk,
  input  logic mr,
  input  logic en,
  output logic hold
);
  always_ff @(negedge clk or posedge mr) begin
    if (mr) hold <= 1'b0;
    else    hold <= en;
  end
endmodule

// File: rtl/clkdiv_release_retime.sv
`timescale 1ns/1ps
// Two-stage release of the master reset: first a falling-edge stage, then a
// rising-edge stage whose output gates counting. Counting starts on the 2nd
// rising edge (release in high phase) or the 3rd (release in low phase).
module clkdiv_release_retime (
  input  logic clk,
  input  logic mr,
  output logic run_ok
);
  logic fall_stage;

  always_ff @(negedge clk or posedge mr) begin
    if (mr) fall_stage <= 1'b0;
    else    fall_stage <= 1'b1;
  end

  always_ff @(posedge clk or posedge mr) begin
    if (mr) run_ok <= 1'b0;
    else    run_ok <= fall_stage;
  end
endmodule

// File: rtl/clkdiv_toggle_chain.sv
`timescale 1ns/1ps
// Synchronous binary toggle chain: bit i toggles when advance is set and all
// lower bits are 1. Every bit is a register clocked on the rising edge.
module clkdiv_toggle_chain #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         mr,
  input  logic         adv,
  output logic [W-1:0] bits
);
  logic [W:0] carry;

  assign carry[0] = adv;

  for (genvar i = 0; i < W; i++) begin : g_stage
    assign carry[i+1] = carry[i] & bits[i];

    always_ff @(posedge clk or posedge mr) begin
      if (mr)            bits[i] <= 1'b0;
      else if (carry[i]) bits[i] <= ~bits[i];
    end
  end
endmodule

// File: rtl/clkdiv_gated_top.sv
`timescale 1ns/1ps
module clkdiv_gated_top #(
  parameter int unsigned CHAIN_W = clkdiv_pkg::CHAIN_W_DEF
) (
  input  logic clk,
  input  logic mr,
  input  logic en,
  output logic q0,
  output logic q1,
  output logic q2
);
  localparam int unsigned W = (CHAIN_W < clkdiv_pkg::OUT_W) ? clkdiv_pkg::OUT_W : CHAIN_W;

  logic         en_hold;
  logic         run_ok;
  logic         adv;
  logic [W-1:0] chain;

  clkdiv_freeze_retime u_freeze (
    .clk  (clk),
    .mr   (mr),
    .en   (en),
    .hold (en_hold)
  );

  clkdiv_release_retime u_release (
    .clk    (clk),
    .mr     (mr),
    .run_ok (run_ok)
  );

  // Advance only after reset release has retimed and while not frozen.
  assign adv = run_ok & ~en_hold;

  clkdiv_toggle_chain #(.W(W)) u_chain (
    .clk  (clk),
    .mr   (mr),
    .adv  (adv),
    .bits (chain)
  );

  assign q0 = chain[0];
  assign q1 = chain[1];
  assign q2 = chain[2];
endmodule

// File: rtl/clkdiv_gated_chk.sv
`timescale 1ns/1ps
module clkdiv_gated_chk (
  input logic       clk,
  input logic       mr,
  input logic       hold,
  input logic       run_ok,
  input logic       adv,
  input logic [2:0] q
);
  p_q0_toggle_r1: assert property (@(posedge clk) disable iff (mr)
    adv |=> (q[0] != $past(q[0])));

  p_q1_step_r2: assert property (@(posedge clk) disable iff (mr)
    (adv && q[0]) |=> (q[1] != $past(q[1])));

  p_q1_keep_r2: assert property (@(posedge clk) disable iff (mr)
    (adv && !q[0]) |=> $stable(q[1]));

  p_q2_step_r3: assert property (@(posedge clk) disable iff (mr)
    (adv && q[0] && q[1]) |=> (q[2] != $past(q[2])));

  p_q2_keep_r3: assert property (@(posedge clk) disable iff (mr)
    (adv && !(q[0] && q[1])) |=> $stable(q[2]));

  p_freeze_r4: assert property (@(posedge clk) disable iff (mr)
    hold |=> $stable(q));

  p_reset_clear_r6: assert property (@(posedge clk)
    mr |-> (q == 3'b000));

  p_gate_release_r7: assert property (@(posedge clk) disable iff (mr)
    !run_ok |=> $stable(q));

  p_run_sticky_r8: assert property (@(posedge clk) disable iff (mr)
    run_ok |=> run_ok);
endmodule

bind clkdiv_gated_top clkdiv_gated_chk chk_i (
  .clk    (clk),
  .mr     (mr),
  .hold   (en_hold),
  .run_ok (run_ok),
  .adv    (adv),
  .q      ({q2, q1, q0})
);

// File: tb/clkdiv_gated_top_tb_top.sv
`timescale 1ns/1ps
module clkdiv_gated_top_tb_top;
  logic clk = 1'b0;
  logic mr  = 1'b0;
  logic en  = 1'b0;
  logic q0, q1, q2;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  localparam int NROWS = 18;
  // en driven just after each falling edge; expected {q2,q1,q0} after the next rising edge.
  localparam bit EN_VEC [0:NROWS-1] = '{
    1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1,
    1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic [2:0] EXP_CNT [0:NROWS-1] = '{
    3'd0, 3'd1, 3'd2, 3'd3, 3'd3, 3'd3, 3'd4, 3'd5, 3'd6,
    3'd6, 3'd7, 3'd0, 3'd1, 3'd2, 3'd2, 3'd2, 3'd2, 3'd3};

  clkdiv_gated_top dut_i (
    .clk (clk),
    .mr  (mr),
    .en  (en),
    .q0  (q0),
    .q1  (q1),
    .q2  (q2)
  );

  always #5 clk = ~clk;

  function automatic logic [2:0] qv();
    return {q2, q1, q0};
  endfunction

  task automatic check(input logic [2:0] exp, input string tag);
    n_chk++;
    if (qv() !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, qv(), exp);
    end
  endtask

  initial begin
    logic [2:0] base;
    #1 mr = 1'b1;
    #1 check(3'd0, "R6 async clear before any clock");
    @(posedge clk); #1 check(3'd0, "R6 held through edge");
    // Release in high phase, then walk the table.
    @(posedge clk); #2 mr = 1'b0;
    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk); #1 en = EN_VEC[i];
      @(posedge clk); #1;
      if (i == 0)                      check(EXP_CNT[i], "R7 no count on first edge");
      else if (EN_VEC[i-1])            check(EXP_CNT[i], "R4 frozen by low-phase en");
      else if (i >= 2 && EN_VEC[i-2])  check(EXP_CNT[i], "R5 resume from held count");
      else if (i == 1)                 check(EXP_CNT[i], "R7 count on second edge");
      else                             check(EXP_CNT[i], "R1 R2 R3 count step");
    end
    // R9: en pulse confined to the high phase.
    #1 en = 1'b1;
    #1 en = 1'b0;
    base = qv();
    @(posedge clk); #1 check(base + 3'd1, "R9 high-phase en pulse ignored");
    // R4/R5 with en changes during the high phase.
    #1 en = 1'b1;
    base = qv();
    @(posedge clk); #1 check(base, "R4 high-phase assert freezes");
    @(posedge clk); #1 check(base, "R4 stays frozen");
    #1 en = 1'b0;
    @(posedge clk); #1 check(base + 3'd1, "R5 high-phase release resumes");
    // R6: mid-run asynchronous clear.
    #2 mr = 1'b1;
    #1 check(3'd0, "R6 mid-run async clear");
    @(posedge clk); #1 check(3'd0, "R6 clear held across edge");
    // R8: release during low phase.
    @(negedge clk); #2 mr = 1'b0;
    @(posedge clk); #1 check(3'd0, "R8 first edge idle");
    @(posedge clk); #1 check(3'd0, "R8 second edge idle");
    @(posedge clk); #1 check(3'd1, "R8 third edge counts");
    // R7: release during high phase.
    #2 mr = 1'b1;
    @(posedge clk); #2 mr = 1'b0;
    @(posedge clk); #1 check(3'd0, "R7 first edge idle");
    @(posedge clk); #1 check(3'd1, "R7 second edge counts");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule